// File: doc/BRIEF.md
# Sleep Wake-Up Interrupt Sequencer

This controller brings a small processor core back out of its low-power sleep state when the external interrupt pin sees a rising edge. The instruction decoder signals a sleep request together with the address of the sleep instruction. The block then stops the core clock and waits for the pin. When the edge comes, it sets the interrupt flag, holds the core for an oscillator start-up delay when a crystal-type oscillator is selected, and lets the instruction that was already fetched (the one after the sleep) execute. After that it either resumes in-line or vectors to a fixed interrupt address through one dummy instruction cycle.

The block runs on the oscillator clock. One clock is one phase, and an instruction cycle is four clocks. Vectoring depends on the global interrupt enable. On a vector jump the block hands the return address (sleep address plus two) to a one-entry return register, and it asks for the global enable to be cleared so that a second interrupt cannot nest. A sleep issued while the interrupt flag is already set does nothing.

Top module: `wake_seq`

## Requirements
- R1: After reset, clk_run=1, exec_en=1, int_flag=0, dummy=0, and pc_load, push and gie_clr are all 0.
- R2: A sleep_req accepted while int_flag is 0 drives clk_run and exec_en to 0 from the next clock until a wake-up.
- R3: A rising edge on ext_int sets int_flag on the next clock, both during sleep and during normal running. In sleep, the same edge starts the wake-up.
- R4: For osc_mode 0 (LP), 1 (XT), 2 (HS) and the reserved codes 5 to 7, exec_en stays 0 for exactly 1024 clocks after the clock that registers the wake edge.
- R5: For osc_mode 3 (external clock) and 4 (RC with I/O), exec_en returns to 1 on the first clock after the wake edge.
- R6: After wake-up, exec_en and clk_run are 1 for one four-clock instruction cycle, during which the instruction fetched before sleep executes and dummy is 0.
- R7: When gie is 1, the block asserts pc_load, push and gie_clr during the last clock of that cycle. At the same time pc_load_addr shows 0x0004 and ret_addr shows the sleep address plus 2, wrapping modulo 2^13. The next four clocks have dummy=1 and exec_en=0, and then normal running resumes.
- R8: When gie is 0, int_flag is still set, no pc_load, push or gie_clr occurs, and normal running follows the first instruction cycle directly with dummy kept at 0.
- R9: A sleep_req that arrives while int_flag is 1 has no effect: clk_run stays 1.
- R10: flag_clr clears int_flag on the next clock unless a new edge arrives in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one clock per phase |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | One-clock pulse from the decoder: sleep instruction executing |
| pc_in | input | 13 | Address of the sleep instruction, sampled with sleep_req |
| ext_int | input | 1 | External interrupt pin, rising edge active |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 3 | 0 LP, 1 XT, 2 HS, 3 external clock, 4 RC with I/O, 5-7 reserved |
| flag_clr | input | 1 | Clear request for the interrupt flag |
| clk_run | output | 1 | Core clock enable |
| exec_en | output | 1 | Instruction execution allowed this clock |
| dummy | output | 1 | Instruction suppressed (dummy cycle) |
| int_flag | output | 1 | External interrupt flag |
| pc_load | output | 1 | Load the program counter from pc_load_addr |
| pc_load_addr | output | 13 | Interrupt vector address |
| push | output | 1 | Write ret_addr into the return register |
| ret_addr | output | 13 | Return address, sleep address plus 2 |
| gie_clr | output | 1 | Request to clear the global interrupt enable |

## Verification
The wake-up path is driven with every combination that changes its outcome: each crystal mode, both delay-free modes and a reserved code, each paired with the enable set or clear. The measured hold time separates the 1024-clock wait from an immediate restart, and the presence or absence of the vector pulses and the dummy cycle separates vectoring from in-line resume. One sleep address sits at the top of the address space, which shows whether the return address wraps. Directed cases cover the reset values, a sleep issued with the flag already set, a pin edge while running, and clearing of the flag.

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int PC_W     = 13,
  parameter int OST_BITS = 10,
  parameter int VEC_ADDR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic [PC_W-1:0] pc_in,
  input  logic            ext_int,
  input  logic            gie,
  input  logic [2:0]      osc_mode,
  input  logic            flag_clr,
  output logic            clk_run,
  output logic            exec_en,
  output logic            dummy,
  output logic            int_flag,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_load_addr,
  output logic            push,
  output logic [PC_W-1:0] ret_addr,
  output logic            gie_clr
);

  localparam logic [OST_BITS-1:0] OST_LAST = '1;

  typedef enum logic [2:0] {S_RUN, S_SLEEP, S_OST, S_RESUME, S_DUMMY} st_t;

  st_t               st, st_nx;
  logic [1:0]        q;
  logic [OST_BITS-1:0] ost_cnt;
  logic              ext_q;
  logic [PC_W-1:0]   sleep_pc;

  wire pin_edge  = ext_int & ~ext_q;
  wire fast_osc  = (osc_mode == 3'd3) || (osc_mode == 3'd4);
  wire cyc_end   = (q == 2'd3);
  wire go_sleep  = (st == S_RUN) && sleep_req && !int_flag && !pin_edge;
  wire vec_now   = (st == S_RESUME) && cyc_end && gie;

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:    if (go_sleep) st_nx = S_SLEEP;
      S_SLEEP:  if (pin_edge) st_nx = fast_osc ? S_RESUME : S_OST;
      S_OST:    if (ost_cnt == OST_LAST) st_nx = S_RESUME;
      S_RESUME: if (cyc_end) st_nx = gie ? S_DUMMY : S_RUN;
      S_DUMMY:  if (cyc_end) st_nx = S_RUN;
      default:  st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RUN;
      q        <= '0;
      ost_cnt  <= '0;
      ext_q    <= 1'b0;
      int_flag <= 1'b0;
      sleep_pc <= '0;
    end else begin
      st    <= st_nx;
      ext_q <= ext_int;
      if (pin_edge)      int_flag <= 1'b1;
      else if (flag_clr) int_flag <= 1'b0;
      if (go_sleep) sleep_pc <= pc_in;
      if (go_sleep)          ost_cnt <= '0;
      else if (st == S_OST)  ost_cnt <= ost_cnt + 1'b1;
      if (st_nx != st)       q <= '0;
      else                   q <= q + 1'b1;
    end
  end

  assign clk_run      = (st != S_SLEEP) && (st != S_OST);
  assign exec_en      = (st == S_RUN) || (st == S_RESUME);
  assign dummy        = (st == S_DUMMY);
  assign pc_load      = vec_now;
  assign push         = vec_now;
  assign gie_clr      = vec_now;
  assign pc_load_addr = PC_W'(VEC_ADDR);
  assign ret_addr     = sleep_pc + PC_W'(2);

  // R2: an accepted sleep stops the core clock on the next clock
  a_r2_sleep_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && !int_flag && !pin_edge) |=> !clk_run);

  // R3: the clock only restarts once the interrupt flag is set
  a_r3_wake_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_run) |-> int_flag);

  // R4: the last start-up count hands over to execution
  a_r4_ost_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OST && ost_cnt == OST_LAST) |=> exec_en);

  // R7: a vector load is always followed by the dummy cycle
  a_r7_load_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> dummy);

  // R7: the dummy cycle begins only after a vector load
  a_r7_dummy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy) |-> $past(pc_load));

  // R9: sleep with the flag already set keeps the clock running
  a_r9_noop_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && int_flag) |=> clk_run);

endmodule

// File: tb/wake_seq_test.sv
`timescale 1ns/1ps
module wake_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic [12:0] pc_in = '0;
  logic        ext_int = 1'b0;
  logic        gie = 1'b0;
  logic [2:0]  osc_mode = '0;
  logic        flag_clr = 1'b0;
  logic        clk_run, exec_en, dummy, int_flag, pc_load, push, gie_clr;
  logic [12:0] pc_load_addr, ret_addr;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wake_seq uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pc_in(pc_in),
    .ext_int(ext_int), .gie(gie), .osc_mode(osc_mode), .flag_clr(flag_clr),
    .clk_run(clk_run), .exec_en(exec_en), .dummy(dummy), .int_flag(int_flag),
    .pc_load(pc_load), .pc_load_addr(pc_load_addr), .push(push),
    .ret_addr(ret_addr), .gie_clr(gie_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {osc_mode, gie, sleep address}
  localparam int NV = 7;
  localparam logic [16:0] VECS [NV] = '{
    {3'd0, 1'b1, 13'h0100},
    {3'd1, 1'b0, 13'h0234},
    {3'd2, 1'b1, 13'h1FFF},
    {3'd3, 1'b1, 13'h0042},
    {3'd4, 1'b0, 13'h0777},
    {3'd3, 1'b0, 13'h1FFE},
    {3'd6, 1'b1, 13'h0010}
  };

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_run && exec_en && !int_flag && !dummy && !pc_load && !push && !gie_clr,
        "R1 reset state", {clk_run, exec_en, int_flag, dummy, pc_load, push, gie_clr}, 7'b1100000);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  m;
      logic        g;
      logic [12:0] a;
      int          hold;
      int          exp_hold;
      {m, g, a} = VECS[i];
      exp_hold = (m == 3'd3 || m == 3'd4) ? 0 : 1024;
      osc_mode = m;
      gie = g;
      @(negedge clk);
      sleep_req = 1'b1;
      pc_in = a;
      @(negedge clk);
      sleep_req = 1'b0;
      pc_in = '0;
      chk(!clk_run && !exec_en, "R2 sleep stops clock", {clk_run, exec_en}, 0);
      repeat (5) @(negedge clk);
      chk(!clk_run, "R2 stays asleep", clk_run, 0);
      ext_int = 1'b1;
      @(negedge clk);
      chk(int_flag, "R3 flag on wake edge", int_flag, 1);
      hold = 0;
      while (!exec_en && hold < 3000) begin
        hold++;
        @(negedge clk);
      end
      chk(hold == exp_hold, (exp_hold != 0) ? "R4 start-up delay" : "R5 no start-up delay",
          hold, exp_hold);
      chk(clk_run && !dummy, "R6 fetched instruction executes", {clk_run, dummy}, 2'b10);
      repeat (3) @(negedge clk);
      chk(exec_en && !dummy, "R6 full instruction cycle", {exec_en, dummy}, 2'b10);
      if (g) begin
        chk(pc_load && push && gie_clr, "R7 vector pulses", {pc_load, push, gie_clr}, 3'b111);
        chk(pc_load_addr == 13'h0004, "R7 vector address", pc_load_addr, 13'h0004);
        chk(ret_addr == a + 13'd2, "R7 return address", ret_addr, a + 13'd2);
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(dummy && !exec_en && !pc_load, "R7 dummy cycle", {dummy, exec_en, pc_load}, 3'b100);
        end
      end else begin
        chk(!pc_load && !push && !gie_clr, "R8 no vector pulses", {pc_load, push, gie_clr}, 0);
      end
      @(negedge clk);
      chk(exec_en && clk_run && !dummy, g ? "R7 run after dummy" : "R8 in-line resume",
          {exec_en, clk_run, dummy}, 3'b110);
      chk(int_flag, g ? "R7 flag kept" : "R8 flag still set", int_flag, 1);
      ext_int = 1'b0;
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(!int_flag, "R10 flag clear", int_flag, 0);
    end

    // edge while running sets flag, then sleep is a no-op
    gie = 1'b1;
    osc_mode = 3'd3;
    ext_int = 1'b1;
    @(negedge clk);
    chk(int_flag && clk_run, "R3 edge while running", {int_flag, clk_run}, 2'b11);
    sleep_req = 1'b1;
    pc_in = 13'h0123;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(clk_run && exec_en, "R9 sleep with flag set ignored", {clk_run, exec_en}, 2'b11);
    repeat (3) @(negedge clk);
    chk(clk_run && !dummy && !pc_load, "R9 still running", {clk_run, dummy, pc_load}, 3'b100);
    ext_int = 1'b0;

    // edge in same clock as clear wins
    @(negedge clk);
    flag_clr = 1'b1;
    ext_int = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(int_flag, "R10 new edge beats clear", int_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(!int_flag, "R10 clear after edge", int_flag, 0);
    ext_int = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule